// File: doc/BRIEF.md
# Page Translation Cache

This block holds a handful of recent virtual-to-physical translations for 4 KiB pages. An I/O master presents a 32-bit virtual address. In the same cycle the cache reports whether it holds a translation for that page. On a hit it also returns the physical address, the read and write permissions and the cache attribute bits of the entry. The low 12 address bits are copied through to the physical address unchanged.

A page-table walker outside the block loads entries after a miss. It hands over the virtual address and the raw 32-bit leaf entry it fetched. The cache keeps only leaf entries whose valid bit is set. A new page goes into the slot named by a round-robin pointer.

Software-driven control can drop a single page by giving any address inside that page, or it can drop every entry in one cycle. A fault-acknowledge request always flushes the whole cache, and the acknowledge goes out only after that flush has taken effect.

Top module: `xlate_cache`

## Requirements
- R1: After reset no lookup hits, and `faultAckDone` is 0.
- R2: Lookup is combinational. When a valid entry's page tag equals `lookupVa[31:12]`, `lookupHit` is 1 in the same cycle and `lookupPa` is the stored frame number in bits 31:12 followed by `lookupVa[11:0]`.
- R3: On a hit, `lookupRd` is bit 1, `lookupWr` is bit 2 and `lookupAttr` is bits 8:3 of the leaf entry that was filled.
- R4: A fill whose leaf entry has bit 0 clear is discarded: no entry changes and the round-robin pointer holds.
- R5: A fill for a page not present writes the slot at the round-robin pointer, which starts at 0 after reset, then advances by one and wraps after slot NUM_ENTRIES-1. With NUM_ENTRIES pages resident, one more new page evicts the earliest filled one.
- R6: A fill for a page already present overwrites that entry in place and leaves the pointer unchanged.
- R7: A line invalidate removes only the entry whose tag equals `invLineVa[31:12]`; the low 12 bits are ignored. A line invalidate that matches nothing changes nothing.
- R8: A global invalidate removes every entry at the next clock edge.
- R9: A fill in the same cycle as a global invalidate, a fault acknowledge, or a line invalidate of the same page is dropped.
- R10: A fault acknowledge request flushes all entries at the next edge. `faultAckDone` is 1 exactly in the following cycle, and by then nothing hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupVa | input | 32 | Virtual address to translate |
| lookupHit | output | 1 | Translation present |
| lookupPa | output | 32 | Physical address on hit |
| lookupRd | output | 1 | Read permission of hit entry |
| lookupWr | output | 1 | Write permission of hit entry |
| lookupAttr | output | 6 | Cache attribute bits of hit entry |
| fillValid | input | 1 | Walker delivers a translation |
| fillVa | input | 32 | Virtual address of filled page |
| fillPte | input | 32 | Raw leaf entry: frame 31:12, attr 8:3, write 2, read 1, valid 0 |
| invLineValid | input | 1 | Invalidate one page |
| invLineVa | input | 32 | Any address within the page to invalidate |
| invAllValid | input | 1 | Invalidate all entries |
| faultAckReq | input | 1 | Request to acknowledge a fault |
| faultAckDone | output | 1 | Fault acknowledge issued after the flush |

## Verification
The assertions assume that every strobe is a clean, reset-qualified level that is sampled once per clock. They also assume that lookups do not rely on any ordering between a fill and a lookup in the same cycle: a fill becomes visible only from the next cycle on. The stimulus drives all inputs at the falling edge and keeps them steady across the rising edge. The random phase draws from a small pool of pages, so hits, in-place refills, evictions and same-page collisions between fills and invalidates all occur often. Fault acknowledges are kept rare, so that the cache fills up between flushes.

// File: rtl/xlate_cache_pkg.sv
package xlate_cache_pkg;
  parameter int VA_W   = 32;
  parameter int PAGE_W = 12;
  parameter int ATTR_W = 6;
  localparam int TAG_W = VA_W - PAGE_W;

  typedef logic [TAG_W-1:0] tcTag_t;

  typedef struct packed {
    logic [TAG_W-1:0]  ppn;
    logic [ATTR_W-1:0] attr;
    logic              wr;
    logic              rd;
  } tcEntry_t;

  typedef struct packed {
    logic wrEn;
    logic invLine;
    logic flushAll;
  } tcStrobe_t;
endpackage

// File: rtl/xlate_cache_ctrl.sv
module xlate_cache_ctrl
  import xlate_cache_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fillValid,
  input  logic             fillPteValid,
  input  tcTag_t           fillTag,
  input  logic             invLineValid,
  input  tcTag_t           invTag,
  input  logic             invAllValid,
  input  logic             faultAckReq,
  input  logic             fillMatch,
  input  logic [IDX_W-1:0] fillMatchIdx,
  output tcStrobe_t        strobe,
  output logic [IDX_W-1:0] wrIdx,
  output logic             faultAckDone
);
  logic [IDX_W-1:0] rrPtr;
  logic             flushNow;
  logic             sameLine;
  logic             accept;

  always_comb begin
    flushNow        = invAllValid | faultAckReq;
    sameLine        = invLineValid && (invTag == fillTag);
    accept          = fillValid && fillPteValid && !flushNow && !sameLine;
    strobe.wrEn     = accept;
    strobe.invLine  = invLineValid && !flushNow;
    strobe.flushAll = flushNow;
    wrIdx           = fillMatch ? fillMatchIdx : rrPtr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr        <= '0;
      faultAckDone <= 1'b0;
    end else begin
      faultAckDone <= faultAckReq;
      if (accept && !fillMatch) begin
        if (rrPtr == IDX_W'(NUM_ENTRIES - 1)) rrPtr <= '0;
        else                                  rrPtr <= rrPtr + 1'b1;
      end
    end
  end

  // R9: flushes and fault acknowledges override fills
  p_flush_drops_fill_r9: assert property (@(posedge clk) disable iff (!rstN)
    (invAllValid || faultAckReq) |-> !strobe.wrEn);

  // R4: an invalid leaf entry never reaches the array and leaves the pointer alone
  p_bad_pte_ignored_r4: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid && !fillPteValid) |=> (rrPtr == $past(rrPtr)));

  // R6: in-place refill keeps the pointer
  p_refill_keeps_ptr_r6: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid && fillMatch) |=> (rrPtr == $past(rrPtr)));

  // R10: acknowledge follows the request by one cycle
  p_ack_follows_r10: assert property (@(posedge clk) disable iff (!rstN)
    faultAckReq |=> faultAckDone);
endmodule

// File: rtl/xlate_cache_data.sv
module xlate_cache_data
  import xlate_cache_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  tcStrobe_t        strobe,
  input  logic [IDX_W-1:0] wrIdx,
  input  tcTag_t           fillTag,
  input  tcEntry_t         fillEntry,
  input  tcTag_t           invTag,
  input  tcTag_t           lookupTag,
  output logic             lookupHit,
  output tcEntry_t         lookupEntry,
  output logic             fillMatch,
  output logic [IDX_W-1:0] fillMatchIdx
);
  logic     [NUM_ENTRIES-1:0] validQ;
  tcTag_t                     tagQ  [NUM_ENTRIES];
  tcEntry_t                   dataQ [NUM_ENTRIES];
  logic     [NUM_ENTRIES-1:0] hitVec;
  logic     [NUM_ENTRIES-1:0] fillVec;
  logic     [NUM_ENTRIES-1:0] invVec;
  logic     [NUM_ENTRIES-1:0] staleVec;
  logic                       prevInv;
  tcTag_t                     prevInvTag;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : gSlot
    assign hitVec[g]   = validQ[g] && (tagQ[g] == lookupTag);
    assign fillVec[g]  = validQ[g] && (tagQ[g] == fillTag);
    assign invVec[g]   = validQ[g] && (tagQ[g] == invTag);
    assign staleVec[g] = validQ[g] && (tagQ[g] == prevInvTag);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ[g] <= 1'b0;
        tagQ[g]   <= '0;
        dataQ[g]  <= '0;
      end else if (strobe.flushAll) begin
        validQ[g] <= 1'b0;
      end else if (strobe.wrEn && (wrIdx == IDX_W'(g))) begin
        validQ[g] <= 1'b1;
        tagQ[g]   <= fillTag;
        dataQ[g]  <= fillEntry;
      end else if (strobe.invLine && invVec[g]) begin
        validQ[g] <= 1'b0;
      end
    end
  end

  always_comb begin
    lookupEntry  = '0;
    fillMatchIdx = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (hitVec[i]) lookupEntry = lookupEntry | dataQ[i];
      if (fillVec[i]) fillMatchIdx = IDX_W'(i);
    end
    lookupHit = |hitVec;
    fillMatch = |fillVec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevInv    <= 1'b0;
      prevInvTag <= '0;
    end else begin
      prevInv    <= strobe.invLine;
      prevInvTag <= invTag;
    end
  end

  // R2: at most one slot can match a lookup
  p_single_hit_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  // R8: a flush leaves nothing valid
  p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flushAll |=> (validQ == '0));

  // R7: after a line invalidate the page is gone
  p_line_gone_r7: assert property (@(posedge clk) disable iff (!rstN)
    prevInv |-> (staleVec == '0));
endmodule

// File: rtl/xlate_cache.sv
module xlate_cache
  import xlate_cache_pkg::*;
#(
  parameter int NUM_ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [VA_W-1:0]   lookupVa,
  output logic              lookupHit,
  output logic [VA_W-1:0]   lookupPa,
  output logic              lookupRd,
  output logic              lookupWr,
  output logic [ATTR_W-1:0] lookupAttr,
  input  logic              fillValid,
  input  logic [VA_W-1:0]   fillVa,
  input  logic [VA_W-1:0]   fillPte,
  input  logic              invLineValid,
  input  logic [VA_W-1:0]   invLineVa,
  input  logic              invAllValid,
  input  logic              faultAckReq,
  output logic              faultAckDone
);
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  tcStrobe_t        strobe;
  logic [IDX_W-1:0] wrIdx;
  logic             fillMatch;
  logic [IDX_W-1:0] fillMatchIdx;
  tcEntry_t         fillEntry;
  tcEntry_t         hitEntry;
  tcTag_t           fillTag;
  tcTag_t           invTag;
  tcTag_t           lookupTag;

  assign fillTag   = fillVa[VA_W-1:PAGE_W];
  assign invTag    = invLineVa[VA_W-1:PAGE_W];
  assign lookupTag = lookupVa[VA_W-1:PAGE_W];

  always_comb begin
    fillEntry.ppn  = fillPte[VA_W-1:PAGE_W];
    fillEntry.attr = fillPte[3+ATTR_W-1:3];
    fillEntry.wr   = fillPte[2];
    fillEntry.rd   = fillPte[1];
  end

  xlate_cache_ctrl #(.NUM_ENTRIES(NUM_ENTRIES)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .fillValid    (fillValid),
    .fillPteValid (fillPte[0]),
    .fillTag      (fillTag),
    .invLineValid (invLineValid),
    .invTag       (invTag),
    .invAllValid  (invAllValid),
    .faultAckReq  (faultAckReq),
    .fillMatch    (fillMatch),
    .fillMatchIdx (fillMatchIdx),
    .strobe       (strobe),
    .wrIdx        (wrIdx),
    .faultAckDone (faultAckDone)
  );

  xlate_cache_data #(.NUM_ENTRIES(NUM_ENTRIES)) u_data (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .wrIdx        (wrIdx),
    .fillTag      (fillTag),
    .fillEntry    (fillEntry),
    .invTag       (invTag),
    .lookupTag    (lookupTag),
    .lookupHit    (lookupHit),
    .lookupEntry  (hitEntry),
    .fillMatch    (fillMatch),
    .fillMatchIdx (fillMatchIdx)
  );

  assign lookupPa   = {hitEntry.ppn, lookupVa[PAGE_W-1:0]};
  assign lookupRd   = hitEntry.rd;
  assign lookupWr   = hitEntry.wr;
  assign lookupAttr = hitEntry.attr;

  // R10: when the acknowledge is out, no stale translation is visible
  p_ack_after_flush_r10: assert property (@(posedge clk) disable iff (!rstN)
    faultAckDone |-> !lookupHit);
endmodule

// File: tb/xlate_cache_tb.sv
module xlate_cache_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] lookupVa = '0;
  logic        lookupHit;
  logic [31:0] lookupPa;
  logic        lookupRd;
  logic        lookupWr;
  logic [5:0]  lookupAttr;
  logic        fillValid = 1'b0;
  logic [31:0] fillVa = '0;
  logic [31:0] fillPte = '0;
  logic        invLineValid = 1'b0;
  logic [31:0] invLineVa = '0;
  logic        invAllValid = 1'b0;
  logic        faultAckReq = 1'b0;
  logic        faultAckDone;

  int total = 0;
  int bad = 0;

  // reference model
  bit          mValid [N];
  logic [19:0] mTag   [N];
  logic [31:0] mPte   [N];
  int          mPtr = 0;
  bit          mDone = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlate_cache #(.NUM_ENTRIES(N)) u_dut (
    .clk(clk), .rstN(rstN), .lookupVa(lookupVa), .lookupHit(lookupHit),
    .lookupPa(lookupPa), .lookupRd(lookupRd), .lookupWr(lookupWr),
    .lookupAttr(lookupAttr), .fillValid(fillValid), .fillVa(fillVa),
    .fillPte(fillPte), .invLineValid(invLineValid), .invLineVa(invLineVa),
    .invAllValid(invAllValid), .faultAckReq(faultAckReq),
    .faultAckDone(faultAckDone)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // compare outputs against the model for the current lookupVa
  task automatic compareModel();
    int idx = -1;
    for (int i = 0; i < N; i++)
      if (mValid[i] && mTag[i] == lookupVa[31:12]) idx = i;
    check(lookupHit == (idx >= 0), "R2 hit", {31'd0, lookupHit}, {31'd0, idx >= 0});
    if (idx >= 0) begin
      check(lookupPa == {mPte[idx][31:12], lookupVa[11:0]}, "R2 pa", lookupPa,
            {mPte[idx][31:12], lookupVa[11:0]});
      check({lookupAttr, lookupWr, lookupRd} == mPte[idx][8:1], "R3 flags",
            {24'd0, lookupAttr, lookupWr, lookupRd}, {24'd0, mPte[idx][8:1]});
    end
    check(faultAckDone == mDone, "R10 ack", {31'd0, faultAckDone}, {31'd0, mDone});
  endtask

  task automatic modelUpdate();
    bit flush = invAllValid || faultAckReq;
    bit same  = invLineValid && (invLineVa[31:12] == fillVa[31:12]);
    int hitIdx = -1;
    mDone = faultAckReq;
    for (int i = 0; i < N; i++)
      if (mValid[i] && mTag[i] == fillVa[31:12]) hitIdx = i;
    if (flush) begin
      for (int i = 0; i < N; i++) mValid[i] = 0;
    end else begin
      if (invLineValid)
        for (int i = 0; i < N; i++)
          if (mValid[i] && mTag[i] == invLineVa[31:12]) mValid[i] = 0;
      if (fillValid && fillPte[0] && !same) begin
        int w = (hitIdx >= 0) ? hitIdx : mPtr;
        mValid[w] = 1; mTag[w] = fillVa[31:12]; mPte[w] = fillPte;
        if (hitIdx < 0) mPtr = (mPtr + 1) % N;
      end
    end
  endtask

  task automatic cycle();
    #1 compareModel();
    @(posedge clk);
    if (rstN) modelUpdate();
    @(negedge clk);
    fillValid = 0; invLineValid = 0; invAllValid = 0; faultAckReq = 0;
  endtask

  task automatic doFill(input logic [31:0] va, input logic [31:0] pte);
    fillValid = 1; fillVa = va; fillPte = pte; cycle();
  endtask

  task automatic expectLookup(input logic [31:0] va, input bit hit,
                              input logic [31:0] pa, input string req);
    lookupVa = va;
    #1;
    check(lookupHit == hit, req, {31'd0, lookupHit}, {31'd0, hit});
    if (hit) check(lookupPa == pa, req, lookupPa, pa);
  endtask

  function automatic logic [31:0] pageB(input int k);
    return 32'h4000_0000 + (k << 12);
  endfunction

  function automatic logic [31:0] pteB(input int k);
    return ((32'h80000 + k) << 12) | 32'h3;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state
    expectLookup(32'h0000_0000, 0, 0, "R1 empty");
    check(faultAckDone == 0, "R1 ack low", {31'd0, faultAckDone}, 0);

    // R2/R3: basic fill and lookup, read+write, attr 0x2A
    doFill(32'h1234_5000, 32'hABCD_E000 | (32'h2A << 3) | 32'h7);
    expectLookup(32'h1234_5ABC, 1, 32'hABCD_EABC, "R2 pa");
    check({lookupAttr, lookupWr, lookupRd} == {6'h2A, 2'b11}, "R3 flags",
          {24'd0, lookupAttr, lookupWr, lookupRd}, {24'd0, 6'h2A, 2'b11});

    // R4: invalid leaf entry is not stored
    doFill(32'h1111_1000, 32'h2222_2006);
    expectLookup(32'h1111_1000, 0, 0, "R4 invalid pte");

    // R5: eight new pages, the eighth wraps to slot 0 and evicts the first
    for (int k = 1; k <= 8; k++) doFill(pageB(k), pteB(k));
    expectLookup(32'h1234_5000, 0, 0, "R5 evicted oldest");
    expectLookup(pageB(1) + 32'h10, 1, ((32'h80001) << 12) + 32'h10, "R5 kept");

    // R6: refill B2 in place; the next new page then evicts B1 (pointer at 1)
    doFill(pageB(2), 32'h9999_9003);
    doFill(32'h5000_0000, 32'h7777_7003);
    expectLookup(pageB(1), 0, 0, "R6 pointer held");
    expectLookup(pageB(2) + 32'h4, 1, 32'h9999_9004, "R6 overwritten");
    expectLookup(pageB(3), 1, (32'h80003) << 12, "R6 neighbour");

    // R7: line invalidate with offset bits, then a missing page
    invLineValid = 1; invLineVa = pageB(3) + 32'hFFF; cycle();
    expectLookup(pageB(3), 0, 0, "R7 removed");
    expectLookup(pageB(4), 1, (32'h80004) << 12, "R7 others kept");
    invLineValid = 1; invLineVa = 32'h6666_6000; cycle();
    expectLookup(pageB(5), 1, (32'h80005) << 12, "R7 miss no-op");
    expectLookup(pageB(4), 1, (32'h80004) << 12, "R7 miss no-op");

    // R9: same-page invalidate beats fill
    fillValid = 1; fillVa = 32'h6000_0000; fillPte = 32'h1212_1003;
    invLineValid = 1; invLineVa = 32'h6000_0123; cycle();
    expectLookup(32'h6000_0000, 0, 0, "R9 line beats fill");

    // R8/R9: global flush with a concurrent fill
    fillValid = 1; fillVa = 32'h6100_0000; fillPte = 32'h1313_1003;
    invAllValid = 1; cycle();
    expectLookup(32'h6100_0000, 0, 0, "R9 flush beats fill");
    expectLookup(pageB(5), 0, 0, "R8 flushed");
    expectLookup(pageB(6), 0, 0, "R8 flushed");

    // R10: fault acknowledge flushes, then signals done
    doFill(32'h7000_0000, 32'h3434_3003);
    fillValid = 1; fillVa = 32'h7100_0000; fillPte = 32'h3535_3003;
    faultAckReq = 1; cycle();
    check(faultAckDone == 1, "R10 done", {31'd0, faultAckDone}, 1);
    expectLookup(32'h7000_0000, 0, 0, "R10 flushed");
    expectLookup(32'h7100_0000, 0, 0, "R10 fill dropped");
    cycle();
    check(faultAckDone == 0, "R10 pulse", {31'd0, faultAckDone}, 0);

    // random phase against the model
    for (int c = 0; c < 3000; c++) begin
      lookupVa     = 32'h4000_0000 + (($urandom % 12) << 12) + ($urandom % 4096);
      fillValid    = ($urandom % 2) == 0;
      fillVa       = 32'h4000_0000 + (($urandom % 12) << 12);
      fillPte      = $urandom;
      invLineValid = ($urandom % 6) == 0;
      invLineVa    = 32'h4000_0000 + (($urandom % 12) << 12) + ($urandom % 4096);
      invAllValid  = ($urandom % 60) == 0;
      faultAckReq  = ($urandom % 80) == 0;
      cycle();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule